// File: doc/BRIEF.md
# EPP Access Engine with Mode Gating and Sticky Timeout

This block adds enhanced-parallel-port transfers to a byte-wide parallel port. A host issues one access at a time on a simple request interface: an offset, a read/write flag, an access size and write data. Offset 3 runs a peripheral address cycle and offset 4 runs a peripheral data cycle. Offset 1 is the status byte and offset 2 is the six-bit control register. An EPP access goes ahead only when the control register is in the exact state that the transfer direction requires. Otherwise a write does nothing and a read returns all ones.

An allowed access is split into byte cycles on the peripheral side. Each cycle raises the address or the data strobe and waits for the peripheral's wait line to rise. It then drops the strobe and waits for the wait line to fall. A phase that stalls beyond the programmable limit ends the access and sets a sticky timeout flag. The flag appears in bit 0 of every status read, and the host clears it by writing to the status offset.

Top module: `epp_port`

## Requirements
- R1: After reset the timeout flag is 0, the control register reads 0xCC, no strobe is active and `pp_dir_in` is 0.
- R2: A write at offset 3 or 4 starts peripheral cycles only when control bits {5,3,2,1,0} are 0,0,1,0,0 (bit 2 the only one set). In any other state no strobe is raised and the timeout flag does not change.
- R3: A read at offset 3 or 4 starts peripheral cycles only when control bits {5,3,2,1,0} are 1,0,1,0,0. In any other state no strobe is raised and the read returns all ones in the low 8, 16 or 32 bits and zero above them.
- R4: In a byte cycle, `pp_astb` (offset 3) or `pp_dstb` (offset 4) stays high until `pp_wait` is seen high. The strobe is then low until `pp_wait` is seen low. `pp_write` is high for the whole cycle of a write, and the two strobes are never high together.
- R5: When a handshake phase goes more than `cyc_limit`+1 cycles without its awaited `pp_wait` edge, the access ends and the timeout flag is set. The flag stays set through later accesses.
- R6: A write to offset 1 with data bit 0 = 1 clears the timeout flag. With bit 0 = 0 the write leaves the flag as it is.
- R7: A status read (offset 1) returns `pp_stat[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R8: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. Offset 3 always moves one byte. Bytes move least significant first, and read bytes are assembled little-endian.
- R9: A multi-byte access stops at the first failed byte: no later strobe is raised, and that byte and every later read byte return 0xFF. `host_busy` stays high until the sequence has ended.
- R10: `pp_dir_in` equals control bit 5 from the cycle after a control write.
- R11: A control read (offset 2) returns 2'b11 above the six stored control bits.
- R12: A read that starts no peripheral cycle gives `host_rvalid` one cycle after acceptance. An access that starts cycles raises `host_busy` from the next cycle. Its read data comes with `host_rvalid` in the cycle `host_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, taken when `host_busy` is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Register offset |
| host_size | input | 2 | Access size code (offset 4) |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | Peripheral sequence in progress |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 32 | Read data |
| cyc_limit | input | LIM_W | Per-phase stall limit in cycles |
| pp_astb | output | 1 | Address strobe, active high |
| pp_dstb | output | 1 | Data strobe, active high |
| pp_write | output | 1 | High during a write cycle |
| pp_dout | output | 8 | Byte driven to the peripheral |
| pp_din | input | 8 | Byte from the peripheral |
| pp_wait | input | 1 | Peripheral handshake line |
| pp_stat | input | 8 | Peripheral status lines |
| pp_dir_in | output | 1 | 1 = data bus driven by the peripheral |

## Verification
The bench targets the gate decode. It uses control states that are one bit away from the allowed pattern, and it reuses a pattern that is right for one direction in the other direction. A loose compare would show up as unexpected strobes or as real data where ones were due. Multi-byte transfers check byte order in both directions, so a swapped order shows as reversed bytes on the bus or in the assembled word. A peripheral that stops answering partway through a transfer shows whether the sequencer halts and fills the remaining bytes with ones. The timeout flag is tested for stickiness, and for clearing only when bit 0 of the status write is 1. A flag that self-clears, or that is cleared by any status write, fails those reads.

// File: rtl/epp_pkg.sv
package epp_pkg;

  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam int unsigned CTL_DIR_BIT = 5;
  localparam logic [5:0] CTL_GATE_MASK = 6'h2F;
  localparam logic [5:0] CTL_WR_STATE  = 6'h04;
  localparam logic [5:0] CTL_RD_STATE  = 6'h24;
  localparam logic [5:0] CTL_RESET     = 6'h0C;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ASSERT  = 2'd1,
    PH_RELEASE = 2'd2
  } epp_phase_e;

  // size code to byte count: 0 -> 1, 1 -> 2, else 4
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_to_bytes = 3'd1;
      2'd1:    size_to_bytes = 3'd2;
      default: size_to_bytes = 3'd4;
    endcase
  endfunction

  // ones in the low nb bytes
  function automatic logic [31:0] width_mask(input logic [2:0] nb);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(nb)) m[k*8 +: 8] = 8'hFF;
    width_mask = m;
  endfunction

  // exact match of the mode bits for the chosen direction
  function automatic logic gate_open(input logic [5:0] ctl, input logic is_write);
    gate_open = ((ctl & CTL_GATE_MASK) == (is_write ? CTL_WR_STATE : CTL_RD_STATE));
  endfunction

  // force byte lanes idx and above to 0xFF
  function automatic logic [31:0] ones_from(input logic [31:0] v, input logic [1:0] idx);
    logic [31:0] r;
    r = v;
    for (int k = 0; k < 4; k++)
      if (k >= int'(idx)) r[k*8 +: 8] = 8'hFF;
    ones_from = r;
  endfunction

endpackage

// File: rtl/epp_ctl_regs.sv
module epp_ctl_regs
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [5:0] ctrl_wdata,
  input  logic       stat_we,
  input  logic       stat_wbit0,
  input  logic       fail_evt,
  output logic [5:0] ctrl_q,
  output logic       tmo_q,
  output logic       tmo_clr
);

  assign tmo_clr = stat_we && stat_wbit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTL_RESET;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= 1'b0;
    end else if (fail_evt) begin
      tmo_q <= 1'b1;
    end else if (tmo_clr) begin
      tmo_q <= 1'b0;
    end
  end

endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic             start_addr,
  input  logic [2:0]       start_nb,
  input  logic [31:0]      start_wdata,
  input  logic [LIM_W-1:0] limit,
  input  logic             pp_wait,
  input  logic [7:0]       pp_din,
  output logic             busy,
  output logic             fail,
  output logic             rd_done,
  output logic [31:0]      rdata,
  output logic             pp_astb,
  output logic             pp_dstb,
  output logic             pp_write,
  output logic [7:0]       pp_dout
);

  epp_phase_e       phase_q;
  logic [1:0]       idx_q;
  logic [LIM_W-1:0] cnt_q;
  logic [2:0]       nb_q;
  logic             wr_q;
  logic             addr_q;
  logic [31:0]      wdata_q;
  logic [31:0]      acc_q;
  logic             done_q;

  logic last_byte;
  logic limit_hit;
  logic strobe_on;

  assign busy      = (phase_q != PH_IDLE);
  assign strobe_on = (phase_q == PH_ASSERT);
  assign last_byte = ({1'b0, idx_q} == (nb_q - 3'd1));
  assign limit_hit = (cnt_q == limit);
  assign fail      = limit_hit &&
                     (((phase_q == PH_ASSERT)  && !pp_wait) ||
                      ((phase_q == PH_RELEASE) &&  pp_wait));

  assign pp_astb  = strobe_on &&  addr_q;
  assign pp_dstb  = strobe_on && !addr_q;
  assign pp_write = busy && wr_q;
  assign pp_dout  = (busy && wr_q) ? wdata_q[idx_q*8 +: 8] : 8'h00;

  assign rd_done = done_q && !wr_q;
  assign rdata   = acc_q & width_mask(nb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      nb_q    <= 3'd1;
      wr_q    <= 1'b0;
      addr_q  <= 1'b0;
      wdata_q <= '0;
      acc_q   <= '1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_ASSERT;
            idx_q   <= '0;
            cnt_q   <= '0;
            nb_q    <= start_nb;
            wr_q    <= start_wr;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
            acc_q   <= '1;
          end
        end
        PH_ASSERT: begin
          if (pp_wait) begin
            if (!wr_q) acc_q[idx_q*8 +: 8] <= pp_din;
            phase_q <= PH_RELEASE;
            cnt_q   <= '0;
          end else if (limit_hit) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RELEASE: begin
          if (!pp_wait) begin
            cnt_q <= '0;
            if (last_byte) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + 2'd1;
              phase_q <= PH_ASSERT;
            end
          end else if (limit_hit) begin
            acc_q   <= ones_from(acc_q, idx_q);
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/epp_port.sv
module epp_port
  import epp_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_wr,
  input  logic [2:0]       host_off,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic             host_busy,
  output logic             host_rvalid,
  output logic [31:0]      host_rdata,
  input  logic [LIM_W-1:0] cyc_limit,
  output logic             pp_astb,
  output logic             pp_dstb,
  output logic             pp_write,
  output logic [7:0]       pp_dout,
  input  logic [7:0]       pp_din,
  input  logic             pp_wait,
  input  logic [7:0]       pp_stat,
  output logic             pp_dir_in
);

  logic [5:0]  ctrl_q;
  logic        tmo_q;
  logic        tmo_clr;
  logic        seq_busy;
  logic        seq_fail;
  logic        seq_rd_done;
  logic [31:0] seq_rdata;

  logic        accept;
  logic        is_epp;
  logic        gate_ok;
  logic        seq_start;
  logic [2:0]  req_nb;
  logic [31:0] imm_data;
  logic        imm_v_q;
  logic [31:0] imm_q;

  assign accept    = host_req && !seq_busy;
  assign is_epp    = (host_off == OFF_EADDR) || (host_off == OFF_EDATA);
  assign gate_ok   = gate_open(ctrl_q, host_wr);
  assign seq_start = accept && is_epp && gate_ok;
  assign req_nb    = (host_off == OFF_EADDR) ? 3'd1 : size_to_bytes(host_size);

  always_comb begin
    case (host_off)
      OFF_STAT: imm_data = {24'h0, pp_stat[7:1], tmo_q};
      OFF_CTRL: imm_data = {24'h0, 2'b11, ctrl_q};
      default:  imm_data = width_mask(req_nb);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_v_q <= 1'b0;
      imm_q   <= '0;
    end else begin
      imm_v_q <= accept && !host_wr && !seq_start;
      if (accept && !host_wr) imm_q <= imm_data;
    end
  end

  epp_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (accept && host_wr && (host_off == OFF_CTRL)),
    .ctrl_wdata (host_wdata[5:0]),
    .stat_we    (accept && host_wr && (host_off == OFF_STAT)),
    .stat_wbit0 (host_wdata[0]),
    .fail_evt   (seq_fail),
    .ctrl_q     (ctrl_q),
    .tmo_q      (tmo_q),
    .tmo_clr    (tmo_clr)
  );

  epp_byte_seq #(.LIM_W(LIM_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (seq_start),
    .start_wr    (host_wr),
    .start_addr  (host_off == OFF_EADDR),
    .start_nb    (req_nb),
    .start_wdata (host_wdata),
    .limit       (cyc_limit),
    .pp_wait     (pp_wait),
    .pp_din      (pp_din),
    .busy        (seq_busy),
    .fail        (seq_fail),
    .rd_done     (seq_rd_done),
    .rdata       (seq_rdata),
    .pp_astb     (pp_astb),
    .pp_dstb     (pp_dstb),
    .pp_write    (pp_write),
    .pp_dout     (pp_dout)
  );

  assign host_busy   = seq_busy;
  assign host_rvalid = imm_v_q || seq_rd_done;
  assign host_rdata  = seq_rd_done ? seq_rdata : imm_q;
  assign pp_dir_in   = ctrl_q[CTL_DIR_BIT];

endmodule

// File: rtl/epp_port_chk.sv
module epp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pp_astb,
  input logic       pp_dstb,
  input logic       pp_write,
  input logic       host_busy,
  input logic       host_rvalid,
  input logic [5:0] ctrl_q,
  input logic       tmo_q,
  input logic       tmo_clr,
  input logic       seq_fail
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pp_astb && pp_dstb)); // R4

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_busy |-> (!pp_astb && !pp_dstb)); // R2

  AST_GATE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pp_astb || pp_dstb) |->
      ((ctrl_q & 6'h2F) == (pp_write ? 6'h04 : 6'h24))); // R3

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !tmo_clr) |=> tmo_q); // R5

  AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |=> tmo_q); // R5

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |=> !tmo_q); // R6

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> !host_busy); // R12

endmodule

bind epp_port epp_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pp_astb     (pp_astb),
  .pp_dstb     (pp_dstb),
  .pp_write    (pp_write),
  .host_busy   (host_busy),
  .host_rvalid (host_rvalid),
  .ctrl_q      (ctrl_q),
  .tmo_q       (tmo_q),
  .tmo_clr     (tmo_clr),
  .seq_fail    (seq_fail)
);

// File: tb/epp_port_test.sv
module epp_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_busy;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic [7:0]  cyc_limit = 8'd8;
  logic        pp_astb, pp_dstb, pp_write, pp_dir_in;
  logic [7:0]  pp_dout;
  logic [7:0]  pp_din = 8'h00;
  logic        pp_wait = 1'b0;
  logic [7:0]  pp_stat = 8'hB9;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  epp_port #(.LIM_W(8)) uut (.*);

  // scoreboard queues
  logic [31:0] exp_rd_q[$];
  string       exp_rd_tag[$];
  logic [9:0]  exp_cyc_q[$];
  logic [7:0]  rd_src[$];

  // peripheral model state
  bit   prev_stb = 0;
  int   dcnt = 0;
  int   served = 0;
  bit   stall_en = 0;
  int   stall_after = 0;
  int   n_stb = 0;
  logic [9:0] seen_cyc;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(input logic [31:0] d, input string tag);
    exp_rd_q.push_back(d);
    exp_rd_tag.push_back(tag);
  endtask

  task automatic exp_cyc(input bit is_addr, input bit wr, input logic [7:0] b);
    exp_cyc_q.push_back({is_addr, wr, b});
  endtask

  // driver: one host access, checks the R12 response timing
  task automatic access(input bit wr, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] d, input bit seq, input string tag);
    @(negedge clk);
    while (host_busy) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_off = off; host_size = sz; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_busy == seq, {tag, " R12 busy after accept"}, 32'(host_busy), 32'(seq));
    if (!wr && !seq)
      chk(host_rvalid == 1'b1, {tag, " R12 rvalid one cycle after accept"}, 32'(host_rvalid), 32'd1);
    while (host_busy) @(negedge clk);
  endtask

  // monitor: read results against expectations
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_rd_q.size() == 0) begin
        chk(1'b0, "unexpected read response", host_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_rd_q.pop_front();
        t = exp_rd_tag.pop_front();
        chk(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  // peripheral model and byte-cycle monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ((pp_astb || pp_dstb) && !prev_stb) begin
        n_stb++;
        seen_cyc = {pp_astb, pp_write, pp_write ? pp_dout : 8'h00};
        if (exp_cyc_q.size() == 0) begin
          chk(1'b0, "R2 R3 unexpected strobe", 32'(seen_cyc), 32'h0);
        end else begin
          logic [9:0] e;
          e = exp_cyc_q.pop_front();
          chk(seen_cyc == e, "R4 R8 byte cycle", 32'(seen_cyc), 32'(e));
        end
        if (!pp_write) pp_din = (rd_src.size() != 0) ? rd_src.pop_front() : 8'hFF;
      end
      prev_stb = pp_astb || pp_dstb;
      if ((pp_astb || pp_dstb) && !pp_wait) begin
        if (!(stall_en && served >= stall_after)) begin
          dcnt++;
          if (dcnt >= 2) begin pp_wait = 1'b1; dcnt = 0; end
        end
      end else if (!(pp_astb || pp_dstb) && pp_wait) begin
        dcnt++;
        if (dcnt >= 2) begin pp_wait = 1'b0; dcnt = 0; served++; end
      end else if (!(pp_astb || pp_dstb)) begin
        dcnt = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(!pp_astb && !pp_dstb && !host_busy, "R1 strobes idle", {pp_astb, pp_dstb}, 0);
    chk(pp_dir_in == 1'b0, "R1 R10 dir after reset", 32'(pp_dir_in), 0);
    exp_rd(32'hB8, "R1 R7 status after reset");
    access(0, 3'd1, 0, 0, 0, "R7 status");
    exp_rd(32'hCC, "R1 R11 control after reset");
    access(0, 3'd2, 0, 0, 0, "R11 ctrl");

    // R2 write dropped in reset control state
    s0 = n_stb;
    access(1, 3'd4, 2, 32'hCAFE0001, 0, "R2 gated write");
    access(1, 3'd3, 0, 32'h5, 0, "R2 gated addr write");
    chk(n_stb == s0, "R2 no strobe when gated", n_stb, s0);

    // enter write state
    access(1, 3'd2, 0, 32'h04, 0, "ctrl write");
    exp_rd(32'hC4, "R11 control readback");
    access(0, 3'd2, 0, 0, 0, "R11 ctrl");
    chk(pp_dir_in == 1'b0, "R10 dir for write state", 32'(pp_dir_in), 0);

    // R4 address write
    exp_cyc(1, 1, 8'h5A);
    access(1, 3'd3, 0, 32'h5A, 1, "R4 addr write");
    // R8 4-byte and 2-byte writes
    exp_cyc(0, 1, 8'h44); exp_cyc(0, 1, 8'h33); exp_cyc(0, 1, 8'h22); exp_cyc(0, 1, 8'h11);
    access(1, 3'd4, 2, 32'h11223344, 1, "R8 4-byte write");
    exp_cyc(0, 1, 8'hEF); exp_cyc(0, 1, 8'hBE);
    access(1, 3'd4, 1, 32'h0000BEEF, 1, "R8 2-byte write");
    exp_cyc(1, 1, 8'h77);
    access(1, 3'd3, 2, 32'h99887777, 1, "R8 addr is single byte");

    // R3 reads in write state return ones
    s0 = n_stb;
    exp_rd(32'hFFFFFFFF, "R3 gated 4-byte read");
    access(0, 3'd4, 2, 0, 0, "R3 gated read");
    exp_rd(32'h000000FF, "R3 gated 1-byte read");
    access(0, 3'd4, 0, 0, 0, "R3 gated read");
    exp_rd(32'h0000FFFF, "R3 gated 2-byte read");
    access(0, 3'd4, 1, 0, 0, "R3 gated read");
    chk(n_stb == s0, "R3 no strobe when gated", n_stb, s0);

    // enter read state
    access(1, 3'd2, 0, 32'h24, 0, "ctrl write");
    chk(pp_dir_in == 1'b1, "R10 dir follows control", 32'(pp_dir_in), 1);
    rd_src.push_back(8'hA1); rd_src.push_back(8'hB2);
    rd_src.push_back(8'hC3); rd_src.push_back(8'hD4);
    exp_cyc(0, 0, 0); exp_cyc(0, 0, 0); exp_cyc(0, 0, 0); exp_cyc(0, 0, 0);
    exp_rd(32'hD4C3B2A1, "R8 4-byte read little-endian");
    access(0, 3'd4, 3, 0, 1, "R8 read");
    rd_src.push_back(8'h3C);
    exp_cyc(1, 0, 0);
    exp_rd(32'h0000003C, "R4 addr read");
    access(0, 3'd3, 1, 0, 1, "R4 addr read");

    // R2 write in read state and near-miss control states
    s0 = n_stb;
    access(1, 3'd4, 0, 32'h12, 0, "R2 write in read state");
    access(1, 3'd2, 0, 32'h2C, 0, "ctrl write");
    exp_rd(32'h000000FF, "R3 select bit set blocks read");
    access(0, 3'd3, 0, 0, 0, "R3 near-miss");
    access(1, 3'd2, 0, 32'h05, 0, "ctrl write");
    access(1, 3'd4, 0, 32'h34, 0, "R2 strobe bit set blocks write");
    chk(n_stb == s0, "R2 R3 no strobe near-miss", n_stb, s0);
    exp_rd(32'hB8, "R2 gated access leaves timeout clear");
    access(0, 3'd1, 0, 0, 0, "R2 status");

    // R5 R9 timeout mid-sequence on read
    access(1, 3'd2, 0, 32'h24, 0, "ctrl write");
    served = 0; stall_after = 2; stall_en = 1;
    rd_src.push_back(8'h10); rd_src.push_back(8'h20);
    exp_cyc(0, 0, 0); exp_cyc(0, 0, 0); exp_cyc(0, 0, 0);
    exp_rd(32'hFFFF2010, "R9 bytes after failure read ones");
    access(0, 3'd4, 2, 0, 1, "R9 stalled read");
    stall_en = 0;
    exp_rd(32'hB9, "R5 R7 timeout flag in status");
    access(0, 3'd1, 0, 0, 0, "R5 status");

    // R5 sticky through a good access
    rd_src.push_back(8'h42);
    exp_cyc(0, 0, 0);
    exp_rd(32'h42, "R5 good read after timeout");
    access(0, 3'd4, 0, 0, 1, "R5 read");
    exp_rd(32'hB9, "R5 flag stays set");
    access(0, 3'd1, 0, 0, 0, "R5 status");

    // R6 clear only with bit0
    access(1, 3'd1, 0, 32'hFE, 0, "R6 write bit0=0");
    exp_rd(32'hB9, "R6 bit0=0 leaves flag");
    access(0, 3'd1, 0, 0, 0, "R6 status");
    access(1, 3'd1, 0, 32'h01, 0, "R6 write bit0=1");
    exp_rd(32'hB8, "R6 bit0=1 clears flag");
    access(0, 3'd1, 0, 0, 0, "R6 status");

    // R9 write stalls on second byte
    access(1, 3'd2, 0, 32'h04, 0, "ctrl write");
    served = 0; stall_after = 1; stall_en = 1;
    exp_cyc(0, 1, 8'hDD); exp_cyc(0, 1, 8'hCC);
    access(1, 3'd4, 2, 32'hAABBCCDD, 1, "R9 stalled write");
    stall_en = 0;
    pp_stat = 8'h40;
    exp_rd(32'h41, "R5 R7 write timeout with new status lines");
    access(0, 3'd1, 0, 0, 0, "R7 status");

    repeat (4) @(negedge clk);
    chk(exp_cyc_q.size() == 0, "R4 all expected byte cycles seen", exp_cyc_q.size(), 0);
    chk(exp_rd_q.size() == 0, "R12 all expected reads returned", exp_rd_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule